// File: doc/BRIEF.md
# Target-Mode Block-Move Phase Sequencer

This block carries out one block-move instruction for a bus controller that has been selected as a SCSI target. A start pulse presents the instruction: a 3-bit phase field, a 24-bit byte count and a data address. The block first makes sure the controller is connected as a target. It then drives the MSG, C/D and I/O phase lines for the whole move and counts bytes off a one-cycle byte strobe. The strobe stands in for the REQ/ACK handshake. The address advances by one and the remaining count drops by one per byte.

In command phase the first byte received is the opcode of a command descriptor block. Its group code can replace the programmed count with the length that group defines. The initiator can assert ATN, or a parity error can be flagged, during the move. A configuration input selects whether either event stops the move at once or is only recorded and reported when the move completes. After a halt, the remaining count and the current address stay on the outputs so that software can resume the move. The end of every instruction is reported as either a one-cycle completion pulse or a one-cycle interrupt pulse with a cause code.

Top module: `tgt_move_seq`

## Requirements
- R1: A start while idle with `target_i` low gives `irq_o` on the next cycle with cause 1 (not target). The block does not become busy, and `count_o` and `addr_o` are unchanged.
- R2: While busy, `phase_o` = {MSG, C/D, I/O} equals the phase field latched at start and does not change. While idle, `phase_o` is 3'b000.
- R3: In command phase (phase field 3'b010), the group code is bits 7:5 of the first command byte, presented on `cmd_group_i` with that byte's strobe. Group 0 sets the count to 6, groups 1 and 2 set it to 10, and group 5 sets it to 12. The first byte counts as one of those bytes.
- R4: In command phase, any other group code (3, 4, 6, 7) leaves the programmed count in force, and the first byte counts toward it.
- R5: In command phase, if the group code is one of the other codes and the programmed count is zero, the first byte gives `irq_o` with cause 2 (illegal instruction). The block goes idle with `count_o` at zero and `addr_o` unchanged.
- R6: Each byte strobe while busy decrements `count_o` by one and increments `addr_o` by one, both on the next cycle. When the count reaches zero, `done_o` pulses for one cycle in the same cycle that busy drops.
- R7: A start in a non-command phase with a count of zero gives a `done_o` pulse on the next cycle, and no busy cycle.
- R8: With `defer_halt_i` low, ATN or a parity error while busy ends the move on the next cycle with `irq_o`. The cause is 4 (parity) if a parity error is present and otherwise 3 (ATN). A byte strobed in the same cycle is still counted.
- R9: With `defer_halt_i` high, the move continues to its full count. At completion `irq_o` is raised in place of `done_o`, with the cause of the first event seen.
- R10: After a halt or completion, `count_o` and `addr_o` hold their values until the next accepted start.
- R11: A start while busy is ignored: the phase, count and address of the running move are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for one instruction |
| target_i | input | 1 | Controller is connected as a target |
| phase_i | input | 3 | Instruction phase field {MSG, C/D, I/O} |
| count_i | input | CNT_W | Programmed byte count |
| addr_i | input | ADDR_W | Starting data address |
| defer_halt_i | input | 1 | 1: report ATN or parity only at completion; 0: halt at once |
| byte_vld_i | input | 1 | One byte transferred this cycle |
| cmd_group_i | input | 3 | Bits 7:5 of the byte strobed this cycle |
| atn_i | input | 1 | ATN from the initiator |
| parity_err_i | input | 1 | Parity error on the bus |
| busy_o | output | 1 | Move in progress |
| phase_o | output | 3 | Driven phase lines {MSG, C/D, I/O} |
| count_o | output | CNT_W | Remaining byte count |
| addr_o | output | ADDR_W | Current data address |
| done_o | output | 1 | One-cycle completion pulse |
| irq_o | output | 1 | One-cycle interrupt pulse |
| cause_o | output | 3 | Interrupt cause: 1 not target, 2 illegal, 3 ATN, 4 parity |

## Verification
The hardest situation to reach is a deferred halt in which ATN and a parity error arrive on different bytes. Only the first of the two may be reported, and only on the byte that ends the move. The stimulus strobes ATN with one byte and a parity error with the next. It then sends the remaining bytes without either event. An immediate-mode run in which ATN and a parity error arrive together, with no byte, checks that parity wins. An immediate halt that shares a cycle with a strobed byte checks that the byte is counted and that the remaining count is kept for resumption.

// File: rtl/tgtmv_pkg.sv
package tgtmv_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_NOT_TGT = 3'd1,
        CAUSE_ILLEGAL = 3'd2,
        CAUSE_ATN     = 3'd3,
        CAUSE_PARITY  = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CMD_HEAD = 2'd1,
        ST_MOVE     = 2'd2
    } state_e;

    localparam logic [2:0] PH_COMMAND = 3'b010;

endpackage

// File: rtl/tgtmv_cdb_len.sv
module tgtmv_cdb_len #(
    parameter int CNT_W = 24
) (
    input  logic [2:0]       group_i,
    input  logic [CNT_W-1:0] prog_i,
    output logic [CNT_W-1:0] len_o
);
    always_comb begin
        unique case (group_i)
            3'd0:        len_o = CNT_W'(6);
            3'd1, 3'd2:  len_o = CNT_W'(10);
            3'd5:        len_o = CNT_W'(12);
            default:     len_o = prog_i;
        endcase
    end
endmodule

// File: rtl/tgtmv_halt_arb.sv
module tgtmv_halt_arb
    import tgtmv_pkg::*;
(
    input  logic   active_i,
    input  logic   atn_i,
    input  logic   parity_i,
    input  logic   defer_i,
    input  cause_e pend_q_i,
    output cause_e event_o,
    output logic   halt_now_o,
    output cause_e pend_d_o,
    output cause_e final_o
);
    always_comb begin
        if (parity_i)      event_o = CAUSE_PARITY;
        else if (atn_i)    event_o = CAUSE_ATN;
        else               event_o = CAUSE_NONE;

        halt_now_o = active_i && !defer_i && (event_o != CAUSE_NONE);

        pend_d_o = pend_q_i;
        if (active_i && defer_i && pend_q_i == CAUSE_NONE) pend_d_o = event_o;

        final_o = (pend_q_i != CAUSE_NONE) ? pend_q_i : event_o;
    end
endmodule

// File: rtl/tgt_move_seq.sv
module tgt_move_seq
    import tgtmv_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              target_i,
    input  logic [2:0]        phase_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              defer_halt_i,
    input  logic              byte_vld_i,
    input  logic [2:0]        cmd_group_i,
    input  logic              atn_i,
    input  logic              parity_err_i,
    output logic              busy_o,
    output logic [2:0]        phase_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o,
    output logic              irq_o,
    output logic [2:0]        cause_o
);
    typedef struct packed {
        state_e            st;
        logic [2:0]        phase;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        cause_e            pend;
        logic              done;
        logic              irq;
        cause_e            cause;
    } seq_t;

    seq_t q, d;

    logic [CNT_W-1:0] cdb_len;
    logic             active;
    cause_e           ev_cause, pend_next, final_cause;
    logic             halt_now;

    assign active = (q.st != ST_IDLE);

    tgtmv_cdb_len #(.CNT_W(CNT_W)) u_len (
        .group_i (cmd_group_i),
        .prog_i  (q.cnt),
        .len_o   (cdb_len)
    );

    tgtmv_halt_arb u_arb (
        .active_i   (active),
        .atn_i      (atn_i),
        .parity_i   (parity_err_i),
        .defer_i    (defer_halt_i),
        .pend_q_i   (q.pend),
        .event_o    (ev_cause),
        .halt_now_o (halt_now),
        .pend_d_o   (pend_next),
        .final_o    (final_cause)
    );

    always_comb begin
        logic took;
        d      = q;
        d.done = 1'b0;
        d.irq  = 1'b0;
        took   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (!target_i) begin
                        d.irq   = 1'b1;
                        d.cause = CAUSE_NOT_TGT;
                    end else begin
                        d.phase = phase_i;
                        d.cnt   = count_i;
                        d.addr  = addr_i;
                        d.pend  = CAUSE_NONE;
                        d.cause = CAUSE_NONE;
                        if (phase_i == PH_COMMAND)  d.st = ST_CMD_HEAD;
                        else if (count_i == '0)     d.done = 1'b1;
                        else                        d.st = ST_MOVE;
                    end
                end
            end
            ST_CMD_HEAD, ST_MOVE: begin
                if (byte_vld_i) begin
                    if (q.st == ST_CMD_HEAD && cdb_len == '0) begin
                        d.st    = ST_IDLE;
                        d.irq   = 1'b1;
                        d.cause = CAUSE_ILLEGAL;
                    end else begin
                        d.cnt  = ((q.st == ST_CMD_HEAD) ? cdb_len : q.cnt) - 1'b1;
                        d.addr = q.addr + 1'b1;
                        took   = 1'b1;
                    end
                end
                if (d.st != ST_IDLE) begin
                    d.pend = pend_next;
                    if (took && d.cnt == '0) begin
                        d.st = ST_IDLE;
                        if (final_cause != CAUSE_NONE) begin
                            d.irq   = 1'b1;
                            d.cause = final_cause;
                        end else begin
                            d.done = 1'b1;
                        end
                    end else if (halt_now) begin
                        d.st    = ST_IDLE;
                        d.irq   = 1'b1;
                        d.cause = ev_cause;
                    end else if (took) begin
                        d.st = ST_MOVE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.phase <= '0;
            q.cnt   <= '0;
            q.addr  <= '0;
            q.pend  <= CAUSE_NONE;
            q.done  <= 1'b0;
            q.irq   <= 1'b0;
            q.cause <= CAUSE_NONE;
        end else begin
            q <= d;
        end
    end

    assign busy_o  = active;
    assign phase_o = active ? q.phase : 3'b000;
    assign count_o = q.cnt;
    assign addr_o  = q.addr;
    assign done_o  = q.done;
    assign irq_o   = q.irq;
    assign cause_o = q.cause;

endmodule

// File: rtl/tgt_move_seq_chk.sv
module tgt_move_seq_chk
    import tgtmv_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              target_i,
    input logic              defer_halt_i,
    input logic              byte_vld_i,
    input logic              atn_i,
    input logic              parity_err_i,
    input logic              busy_o,
    input logic [2:0]        phase_o,
    input logic [CNT_W-1:0]  count_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              done_o,
    input logic              irq_o,
    input logic [2:0]        cause_o
);
    a_r1_not_target: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && cause_o == CAUSE_NOT_TGT) |-> $past(start_i && !target_i && !busy_o));

    a_r2_idle_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> phase_o == 3'b000);

    a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(phase_o));

    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o && byte_vld_i)) |-> addr_o == $past(addr_o) + 1'b1);

    a_r6_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (count_o == '0 && !busy_o));

    a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && irq_o));

    a_r8_immediate_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !defer_halt_i && (atn_i || parity_err_i)) |=> (!busy_o && irq_o));

    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o) && !$past(start_i)) |-> ($stable(count_o) && $stable(addr_o)));
endmodule

bind tgt_move_seq tgt_move_seq_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .target_i     (target_i),
    .defer_halt_i (defer_halt_i),
    .byte_vld_i   (byte_vld_i),
    .atn_i        (atn_i),
    .parity_err_i (parity_err_i),
    .busy_o       (busy_o),
    .phase_o      (phase_o),
    .count_o      (count_o),
    .addr_o       (addr_o),
    .done_o       (done_o),
    .irq_o        (irq_o),
    .cause_o      (cause_o)
);

// File: tb/tgt_move_seq_bench.sv
module tgt_move_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 0, target_i = 0, defer_halt_i = 0;
    logic [2:0]  phase_i = 0, cmd_group_i = 0;
    logic [23:0] count_i = 0;
    logic [31:0] addr_i = 0;
    logic        byte_vld_i = 0, atn_i = 0, parity_err_i = 0;
    logic        busy_o, done_o, irq_o;
    logic [2:0]  phase_o, cause_o;
    logic [23:0] count_o;
    logic [31:0] addr_o;

    always #10 clk = ~clk;

    tgt_move_seq u_tgt_move_seq (.*);

    int errors = 0, checks = 0;
    bit finished = 0;

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int          m_st = 0, m_ph = 0, m_cnt = 0, m_pend = 0, m_cause = 0;
    logic [31:0] m_addr = 0;
    bit          m_done = 0, m_irq = 0;

    always @(posedge clk) begin
        int ev, n, fin;
        bit took;
        if (!rst_n) begin
            m_st = 0; m_ph = 0; m_cnt = 0; m_addr = 0; m_pend = 0;
            m_done = 0; m_irq = 0; m_cause = 0;
        end else begin
            m_done = 0; m_irq = 0; took = 0;
            ev = parity_err_i ? 4 : (atn_i ? 3 : 0);
            if (m_st == 0) begin
                if (start_i) begin
                    if (!target_i) begin m_irq = 1; m_cause = 1; end
                    else begin
                        m_ph = phase_i; m_cnt = count_i; m_addr = addr_i;
                        m_pend = 0; m_cause = 0;
                        if (phase_i == 3'b010) m_st = 1;
                        else if (count_i == 0) m_done = 1;
                        else m_st = 2;
                    end
                end
            end else begin
                if (byte_vld_i) begin
                    if (m_st == 1) begin
                        case (cmd_group_i)
                            0: n = 6;
                            1, 2: n = 10;
                            5: n = 12;
                            default: n = m_cnt;
                        endcase
                    end else n = m_cnt;
                    if (m_st == 1 && n == 0) begin
                        m_st = 0; m_irq = 1; m_cause = 2;
                    end else begin
                        m_cnt = n - 1; m_addr = m_addr + 1; took = 1;
                    end
                end
                if (m_st != 0) begin
                    if (defer_halt_i && m_pend == 0) fin = ev; else fin = m_pend;
                    if (took && m_cnt == 0) begin
                        m_st = 0;
                        if (m_pend != 0 || ev != 0) begin
                            m_irq = 1; m_cause = (m_pend != 0) ? m_pend : ev;
                        end else m_done = 1;
                    end else if (ev != 0 && !defer_halt_i) begin
                        m_st = 0; m_irq = 1; m_cause = ev;
                    end else if (took) m_st = 2;
                    m_pend = fin;
                end
            end
        end
    end

    // per-cycle comparison and event capture
    int seen_done = 0, seen_irq = 0, last_cause = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 R6 busy",    busy_o,  m_st != 0);
            chk("R2 phase",      phase_o, (m_st != 0) ? m_ph : 0);
            chk("R3 R4 R6 count", count_o, m_cnt);
            chk("R6 R10 addr",   addr_o,  m_addr);
            chk("R6 R7 done",    done_o,  m_done);
            chk("R8 R9 irq",     irq_o,   m_irq);
            chk("R1 R5 cause",   cause_o, m_cause);
            if (done_o) seen_done++;
            if (irq_o) begin seen_irq++; last_cause = cause_o; end
        end
    end

    task automatic step(bit vld, logic [2:0] grp, bit atn, bit par);
        @(negedge clk);
        byte_vld_i = vld; cmd_group_i = grp; atn_i = atn; parity_err_i = par;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    task automatic launch(logic [2:0] ph, int cnt, logic [31:0] a, bit tgt, bit dfr);
        @(negedge clk);
        seen_done = 0; seen_irq = 0; last_cause = 0;
        byte_vld_i = 0; atn_i = 0; parity_err_i = 0;
        start_i = 1; phase_i = ph; count_i = cnt[23:0]; addr_i = a;
        target_i = tgt; defer_halt_i = dfr;
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic bytes(int n, logic [2:0] first_grp);
        for (int i = 0; i < n; i++) begin
            step(1, (i == 0) ? first_grp : 3'd7, 0, 0);
            if (i % 3 == 1) step(0, 0, 0, 0);
        end
        idle(2);
    endtask

    task automatic outcome(string tag, int exp_cause, int exp_cnt, logic [31:0] exp_addr);
        if (exp_cause == 0) begin
            chk({tag, " done pulses"}, seen_done, 1);
            chk({tag, " irq pulses"}, seen_irq, 0);
        end else begin
            chk({tag, " irq pulses"}, seen_irq, 1);
            chk({tag, " cause"}, last_cause, exp_cause);
        end
        chk({tag, " remaining"}, count_o, exp_cnt);
        chk({tag, " address"}, addr_o, exp_addr);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 reset busy", busy_o, 0);
        chk("R2 reset phase", phase_o, 0);
        chk("R6 reset done", done_o, 0);
        chk("R8 reset irq", irq_o, 0);
        rst_n = 1;
        idle(2);

        launch(3'b001, 4, 32'h100, 1, 0); bytes(4, 0);  outcome("R6 data-in", 0, 0, 32'h104);
        launch(3'b010, 100, 32'h200, 1, 0); bytes(6, 0); outcome("R3 group0", 0, 0, 32'h206);
        launch(3'b010, 3, 32'h300, 1, 0); bytes(10, 1);  outcome("R3 group1", 0, 0, 32'h30A);
        launch(3'b010, 0, 32'h400, 1, 0); bytes(10, 2);  outcome("R3 group2", 0, 0, 32'h40A);
        launch(3'b010, 1, 32'h500, 1, 0); bytes(12, 5);  outcome("R3 group5", 0, 0, 32'h50C);
        launch(3'b010, 3, 32'h600, 1, 0); bytes(3, 6);   outcome("R4 group6", 0, 0, 32'h603);
        launch(3'b010, 2, 32'h680, 1, 0); bytes(2, 3);   outcome("R4 group3", 0, 0, 32'h682);
        launch(3'b010, 0, 32'h700, 1, 0); step(1, 7, 0, 0); idle(2);
        outcome("R5 illegal", 2, 0, 32'h700);
        launch(3'b000, 0, 32'h780, 1, 0); idle(2);       outcome("R7 zero count", 0, 0, 32'h780);
        launch(3'b110, 9, 32'h800, 0, 0); idle(2);
        outcome("R1 not target", 1, 0, 32'h780);
        chk("R1 stays idle", busy_o, 0);

        launch(3'b000, 8, 32'h900, 1, 0);
        step(1, 0, 0, 0); step(1, 0, 0, 0); step(1, 0, 0, 0); step(1, 0, 1, 0); idle(2);
        outcome("R8 atn immediate", 3, 4, 32'h904);
        idle(4);
        chk("R10 count kept", count_o, 4);
        chk("R10 addr kept", addr_o, 32'h904);

        launch(3'b011, 5, 32'hA00, 1, 0);
        step(1, 0, 0, 0); step(0, 0, 1, 1); idle(2);
        outcome("R8 parity wins", 4, 4, 32'hA01);

        launch(3'b111, 5, 32'hB00, 1, 1);
        step(1, 0, 1, 0); step(1, 0, 0, 1); step(0, 0, 0, 0);
        chk("R9 still busy", busy_o, 1);
        step(1, 0, 0, 0); step(1, 0, 0, 0); step(1, 0, 0, 0); idle(2);
        outcome("R9 deferred", 3, 0, 32'hB05);

        launch(3'b001, 2, 32'hC00, 1, 1); bytes(2, 0); outcome("R9 defer clean", 0, 0, 32'hC02);

        launch(3'b001, 3, 32'hD00, 1, 0);
        step(1, 0, 0, 0);
        @(negedge clk);
        byte_vld_i = 0; start_i = 1; phase_i = 3'b111; count_i = 50; addr_i = 32'hE00;
        @(negedge clk);
        start_i = 0;
        chk("R11 phase kept", phase_o, 3'b001);
        chk("R11 count kept", count_o, 2);
        bytes(2, 0);
        outcome("R11 ignore start", 0, 0, 32'hD03);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule